// File: doc/BRIEF.md
# Single-Wire Transaction Initiator

This block is the initiating end of a half-duplex link that shares one open-drain wire with a single target. A pull-up holds the wire high when neither end drives it. The pad is modelled as a drive enable plus a drive value, and the wire level comes back in as an input. The host asks for a transaction by pulsing `start` with a 4-bit index. The block first drops the wire to wake the target. It then sends the index with a population-count guard and waits for the target to acknowledge. Next it takes a fixed number of bytes from the target and reverses the wire's direction. It then sends a fixed number of bytes to the target, releases the wire high and reports a 2-bit result with a one-clock `done` strobe.

Every chunk on the wire uses the same framing, whichever end sends it. The sender holds the wire low for one bit period and then high for one bit period as a sync. The data bits follow, most significant first, and then an even-parity bit. Each bit lasts `BIT_CLKS` system clocks, and the sender leaves the wire low afterwards. Received bytes come out on a valid strobe. Transmitted bytes are pulled through a ready/valid pair. Either byte count may be set to zero, and the matching phase is then skipped.

Top module: `swire_initiator`

## Requirements
- R1: After reset the block drives the wire high (`line_oe`=1, `line_out`=1), with `busy` and `done` low, and it keeps driving high whenever it is idle.
- R2: A start whose index exceeds `MAX_INDEX` raises `done` on the next clock with result code 3 (type error), and the wire stays driven high throughout.
- R3: A start with an index in range drives the wire low for exactly `WAKE_CLKS`+`BIT_CLKS` clocks, then high for `BIT_CLKS` clocks.
- R4: The index chunk is 7 data bits, MSB first: index[3:0] followed by the 3-bit count of ones in the index. A parity bit follows, equal to the XOR of those 7 bits. The block then holds the wire low for `BIT_CLKS`/2 clocks and releases it.
- R5: After release the block waits for the wire to read high and then samples it every `POLL_CLKS` clocks. A low sample counts as the acknowledge. If `ACK_POLLS` consecutive samples read high, the block ends with result code 1 (no response) and drives the wire high.
- R6: Each byte from the target is captured mid-bit after the target's sync rise. Every byte with correct parity appears on `rx_data` with a one-clock `rx_valid`, in the order received.
- R7: A received byte with wrong parity ends the transaction at once with result code 2 (data error) and the wire driven high. The bad byte is never presented, and bytes before it already were.
- R8: After the last received byte the block stays released until the target's sync rise. The wire input passes a two-stage synchronizer. The block drives the wire low again exactly `BIT_CLKS`+3 clocks after the target raises it, so it never drives while the target still holds the wire.
- R9: Bytes to send are taken one at a time when `tx_ready` and `tx_valid` are both high, and `tx_ready` is high only while the wire is held low. Each byte is framed as in R4: sync, 8 bits MSB first, then an even-parity bit.
- R10: After the last sent byte the wire is held low for `BIT_CLKS` clocks and then driven high, and `done` rises with result code 0 (end).
- R11: `done` is a single-clock strobe, and `result` holds its code from that strobe until the next transaction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (sampled while idle) |
| idx | input | 4 | Transaction index |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-clock end-of-transaction strobe |
| result | output | 2 | 0 end, 1 no response, 2 data error, 3 type error |
| rx_data | output | 8 | Byte received from the target |
| rx_valid | output | 1 | One-clock strobe qualifying `rx_data` |
| tx_data | input | 8 | Byte to send to the target |
| tx_valid | input | 1 | `tx_data` is available |
| tx_ready | output | 1 | Block takes `tx_data` on this clock if `tx_valid` |
| line_in | input | 1 | Level sensed on the wire |
| line_oe | output | 1 | Drive enable for the wire |
| line_out | output | 1 | Value driven when `line_oe` is high |

## Verification
The bench sweeps all sixteen indices. Indices at or below `MAX_INDEX` run complete transactions against a modelled target, and those above it must end with a type error and leave the wire untouched. This separates the range check from the guard encoding and the parity for every index value. The payloads include all-zero and all-one bytes next to mixed patterns, which exposes bit-order and parity-polarity faults. Two acknowledge delays exercise the poll loop early and late in its window, and a silent target forces the no-response path. A wrong parity bit placed on the first and then on the second received byte shows whether earlier bytes were kept and the bad one dropped.

// File: rtl/swire_pkg.sv
package swire_pkg;

  typedef enum logic [1:0] {
    RES_END    = 2'd0,
    RES_NORESP = 2'd1,
    RES_DATA   = 2'd2,
    RES_TYPE   = 2'd3
  } swire_result_e;

  typedef enum logic [4:0] {
    S_IDLE, S_WAKE, S_SYNC_LO, S_SYNC_HI, S_BITS, S_HALF,
    S_ACK_HI, S_POLL, S_RX_LO, S_RX_HI, S_RX_BIT,
    S_TURN_LO, S_TURN_HI, S_TURN_FULL, S_TURN_HALF,
    S_FETCH, S_FIN
  } swire_state_e;

  function automatic logic [2:0] ones4(input logic [3:0] v);
    return 3'(v[0]) + 3'(v[1]) + 3'(v[2]) + 3'(v[3]);
  endfunction

endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/swire_timer.sv
module swire_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val - W'(1);
    else if (cnt_q != '0)  cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  p_load_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));
endmodule

// File: rtl/swire_initiator.sv
module swire_initiator
  import swire_pkg::*;
#(
  parameter int BIT_CLKS  = 8,
  parameter int WAKE_CLKS = 16,
  parameter int POLL_CLKS = 4,
  parameter int ACK_POLLS = 6,
  parameter int RX_BYTES  = 2,
  parameter int TX_BYTES  = 2,
  parameter int MAX_INDEX = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] idx,
  output logic       busy,
  output logic       done,
  output logic [1:0] result,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic       line_in,
  output logic       line_oe,
  output logic       line_out
);
  localparam int HALF   = BIT_CLKS / 2;
  localparam int T_A    = (WAKE_CLKS > BIT_CLKS + HALF) ? WAKE_CLKS : BIT_CLKS + HALF;
  localparam int T_MAX  = (T_A > POLL_CLKS) ? T_A : POLL_CLKS;
  localparam int TW     = $clog2(T_MAX + 1);
  localparam int PW     = $clog2(ACK_POLLS + 1);
  localparam int RXW    = (RX_BYTES > 1) ? $clog2(RX_BYTES) : 1;
  localparam int TXW    = (TX_BYTES > 1) ? $clog2(TX_BYTES) : 1;
  localparam int RX_LAST = (RX_BYTES > 0) ? RX_BYTES - 1 : 0;
  localparam int TX_LAST = (TX_BYTES > 0) ? TX_BYTES - 1 : 0;
  localparam bit HAS_RX = (RX_BYTES > 0);
  localparam bit HAS_TX = (TX_BYTES > 0);
  localparam logic [TW-1:0] LV_BIT  = TW'(BIT_CLKS);
  localparam logic [TW-1:0] LV_HALF = TW'(HALF);
  localparam logic [TW-1:0] LV_MID  = TW'(BIT_CLKS + HALF);
  localparam logic [TW-1:0] LV_WAKE = TW'(WAKE_CLKS);
  localparam logic [TW-1:0] LV_POLL = TW'(POLL_CLKS);

  swire_state_e   state_q, state_d;
  logic [8:0]     sh_q, sh_d;
  logic [7:0]     rxsh_q, rxsh_d;
  logic [3:0]     bitc_q, bitc_d;
  logic [RXW-1:0] rxc_q, rxc_d;
  logic [TXW-1:0] txc_q, txc_d;
  logic [PW-1:0]  poll_q, poll_d;
  logic           idxph_q, idxph_d;
  logic           done_q, done_d;
  logic           rxv_q, rxv_d;
  logic [1:0]     res_q, res_d;
  logic           tmr_load, tmr_exp;
  logic [TW-1:0]  tmr_val;
  logic           line_s;
  logic [2:0]     idx_ones;

  swire_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s));

  swire_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp));

  assign idx_ones = ones4(idx);

  always_comb begin
    state_d  = state_q;  sh_d  = sh_q;   rxsh_d = rxsh_q; bitc_d = bitc_q;
    rxc_d    = rxc_q;    txc_d = txc_q;  poll_d = poll_q; idxph_d = idxph_q;
    res_d    = res_q;    done_d = 1'b0;  rxv_d  = 1'b0;
    tmr_load = 1'b0;     tmr_val = LV_BIT; tx_ready = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        if ({1'b0, idx} > 5'(MAX_INDEX)) begin
          done_d = 1'b1; res_d = RES_TYPE;
        end else begin
          sh_d = {idx, idx_ones, ^{idx, idx_ones}, 1'b0};
          bitc_d = '0; idxph_d = 1'b1;
          state_d = S_WAKE; tmr_load = 1'b1; tmr_val = LV_WAKE;
        end
      end
      S_WAKE:    if (tmr_exp) begin state_d = S_SYNC_LO; tmr_load = 1'b1; end
      S_SYNC_LO: if (tmr_exp) begin state_d = S_SYNC_HI; tmr_load = 1'b1; end
      S_SYNC_HI: if (tmr_exp) begin state_d = S_BITS;    tmr_load = 1'b1; end
      S_BITS: if (tmr_exp) begin
        sh_d = {sh_q[7:0], 1'b0};
        bitc_d = bitc_q + 4'd1;
        if (bitc_q == (idxph_q ? 4'd7 : 4'd8)) begin
          if (idxph_q) begin
            state_d = S_HALF; tmr_load = 1'b1; tmr_val = LV_HALF;
          end else if (txc_q == TXW'(TX_LAST)) begin
            state_d = S_FIN; tmr_load = 1'b1;
          end else begin
            txc_d = txc_q + TXW'(1); state_d = S_FETCH;
          end
        end else tmr_load = 1'b1;
      end
      S_HALF:   if (tmr_exp) state_d = S_ACK_HI;
      S_ACK_HI: if (line_s) begin
        poll_d = '0; state_d = S_POLL; tmr_load = 1'b1; tmr_val = LV_POLL;
      end
      S_POLL: if (tmr_exp) begin
        if (!line_s) begin
          rxc_d = '0;
          state_d = HAS_RX ? S_RX_LO : S_TURN_LO;
        end else if (poll_q == PW'(ACK_POLLS - 1)) begin
          state_d = S_IDLE; done_d = 1'b1; res_d = RES_NORESP;
        end else begin
          poll_d = poll_q + PW'(1); tmr_load = 1'b1; tmr_val = LV_POLL;
        end
      end
      S_RX_LO: if (!line_s) state_d = S_RX_HI;
      S_RX_HI: if (line_s) begin
        bitc_d = '0; state_d = S_RX_BIT; tmr_load = 1'b1; tmr_val = LV_MID;
      end
      S_RX_BIT: if (tmr_exp) begin
        if (bitc_q == 4'd8) begin
          if ((^rxsh_q) == line_s) begin
            rxv_d = 1'b1;
            rxc_d = rxc_q + RXW'(1);
            state_d = (rxc_q == RXW'(RX_LAST)) ? S_TURN_LO : S_RX_LO;
          end else begin
            state_d = S_IDLE; done_d = 1'b1; res_d = RES_DATA;
          end
        end else begin
          rxsh_d = {rxsh_q[6:0], line_s};
          bitc_d = bitc_q + 4'd1; tmr_load = 1'b1;
        end
      end
      S_TURN_LO:   if (!line_s) state_d = S_TURN_HI;
      S_TURN_HI:   if (line_s) begin state_d = S_TURN_FULL; tmr_load = 1'b1; end
      S_TURN_FULL: if (tmr_exp) begin
        state_d = S_TURN_HALF; tmr_load = 1'b1; tmr_val = LV_HALF;
      end
      S_TURN_HALF: if (tmr_exp) begin
        txc_d = '0; idxph_d = 1'b0;
        if (HAS_TX) state_d = S_FETCH;
        else begin state_d = S_FIN; tmr_load = 1'b1; end
      end
      S_FETCH: begin
        tx_ready = 1'b1;
        if (tx_valid) begin
          sh_d = {tx_data, ^tx_data}; bitc_d = '0;
          state_d = S_SYNC_LO; tmr_load = 1'b1;
        end
      end
      S_FIN: if (tmr_exp) begin
        state_d = S_IDLE; done_d = 1'b1; res_d = RES_END;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; sh_q <= '0; rxsh_q <= '0; bitc_q <= '0;
      rxc_q <= '0; txc_q <= '0; poll_q <= '0; idxph_q <= 1'b0;
      done_q <= 1'b0; rxv_q <= 1'b0; res_q <= RES_END;
    end else begin
      state_q <= state_d; sh_q <= sh_d; rxsh_q <= rxsh_d; bitc_q <= bitc_d;
      rxc_q <= rxc_d; txc_q <= txc_d; poll_q <= poll_d; idxph_q <= idxph_d;
      done_q <= done_d; rxv_q <= rxv_d; res_q <= res_d;
    end
  end

  always_comb begin
    unique case (state_q)
      S_ACK_HI, S_POLL, S_RX_LO, S_RX_HI, S_RX_BIT,
      S_TURN_LO, S_TURN_HI, S_TURN_FULL: begin line_oe = 1'b0; line_out = 1'b1; end
      S_IDLE, S_SYNC_HI:                 begin line_oe = 1'b1; line_out = 1'b1; end
      S_BITS:                            begin line_oe = 1'b1; line_out = sh_q[8]; end
      default:                           begin line_oe = 1'b1; line_out = 1'b0; end
    endcase
  end

  assign busy     = (state_q != S_IDLE);
  assign done     = done_q;
  assign result   = res_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxsh_q;

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (line_oe && line_out));
  p_type_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && ({1'b0, idx} > 5'(MAX_INDEX))) |=> (done && result == 2'd3 && !busy));
  p_release_from_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_oe) |-> !$past(line_out));
  p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_POLL) |-> (poll_q < PW'(ACK_POLLS)));
  p_rx_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_fetch_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (line_oe && !line_out));
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && line_oe && line_out));
  p_done_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/swire_initiator_test.sv
`timescale 1ns/1ps
module swire_initiator_test;
  localparam int B  = 8;
  localparam int H  = B / 2;
  localparam int WK = 16;
  localparam int NRX = 2;
  localparam int NTX = 2;
  localparam int MAXI = 11;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [3:0] idx;
  logic busy, done, rx_valid, tx_ready, tx_valid, line_oe, line_out;
  logic [1:0] result;
  logic [7:0] rx_data, tx_data;
  logic line_in;
  logic tgt_en, tgt_val;

  int nvec = 0, nerr = 0, cont = 0, rx_n = 0, tx_ptr = 0;
  logic [7:0] rx_got [4];
  logic [7:0] tx_mem [NTX];

  always #4 clk = ~clk;

  assign line_in = line_oe ? line_out : (tgt_en ? tgt_val : 1'b1);
  assign tx_data = tx_mem[tx_ptr % NTX];

  swire_initiator #(.BIT_CLKS(B), .WAKE_CLKS(WK), .POLL_CLKS(4), .ACK_POLLS(6),
                    .RX_BYTES(NRX), .TX_BYTES(NTX), .MAX_INDEX(MAXI)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .idx(idx), .busy(busy), .done(done),
    .result(result), .rx_data(rx_data), .rx_valid(rx_valid), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .line_in(line_in), .line_oe(line_oe),
    .line_out(line_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rxb(input int i, input int k);
    if (i == 0) return (k == 0) ? 8'h00 : 8'hFF;
    return 8'((i * 53 + k * 29 + 17) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] txb(input int i, input int k);
    if (i == 1) return (k == 0) ? 8'hFF : 8'h00;
    return 8'((i * 71 + k * 13 + 5) ^ 8'hC3);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        if (rx_n < 4) rx_got[rx_n] = rx_data;
        rx_n++;
      end
      if (line_oe && tgt_en) cont++;
    end
  end

  initial begin
    bit pend = 1'b0;
    forever begin
      @(negedge clk);
      if (pend) tx_ptr++;
      pend = tx_ready && tx_valid;
    end
  end

  task automatic t_recv(input int nbits, output int lowcnt, output logic [8:0] v);
    v = '0;
    do @(negedge clk); while (line_in !== 1'b0);
    lowcnt = 1;
    @(negedge clk);
    while (line_in !== 1'b1) begin lowcnt++; @(negedge clk); end
    repeat (B + H) @(negedge clk);
    v = {v[7:0], line_in};
    for (int k = 0; k < nbits; k++) begin
      repeat (B) @(negedge clk);
      v = {v[7:0], line_in};
    end
  endtask

  task automatic t_send(input logic [7:0] b, input bit badpar);
    tgt_en = 1'b1; tgt_val = 1'b0;
    repeat (B) @(negedge clk);
    tgt_val = 1'b1;
    repeat (B) @(negedge clk);
    for (int k = 7; k >= 0; k--) begin
      tgt_val = b[k];
      repeat (B) @(negedge clk);
    end
    tgt_val = (^b) ^ badpar;
    repeat (B) @(negedge clk);
    tgt_val = 1'b0;
  endtask

  // mode 0: normal, 1: silent target, 2: bad parity on byte badk
  task automatic run_txn(input int i, input int mode, input int ackd, input int badk);
    int lowcnt, turn_c, res, d_oe, d_out, d_next;
    logic [8:0] iv;
    logic [8:0] tv [NTX];
    rx_n = 0; tx_ptr = 0; cont = 0; turn_c = 0;
    for (int k = 0; k < NTX; k++) tx_mem[k] = txb(i, k);
    fork
      begin
        idx = 4'(i); start = 1'b1;
        @(negedge clk); start = 1'b0;
        do @(negedge clk); while (done !== 1'b1);
        res = int'(result); d_oe = int'(line_oe); d_out = int'(line_out);
        @(negedge clk); d_next = int'(done);
      end
      begin
        t_recv(7, lowcnt, iv);
        if (mode != 1) begin
          do @(negedge clk); while (line_oe !== 1'b0);
          repeat (ackd) @(negedge clk);
          tgt_en = 1'b1; tgt_val = 1'b0;
          for (int k = 0; k < NRX; k++) begin
            if (mode == 2 && k > badk) break;
            t_send(rxb(i, k), (mode == 2) && (k == badk));
          end
          if (mode == 2) tgt_en = 1'b0;
          else begin
            repeat (B) @(negedge clk);
            tgt_val = 1'b1;
            while (turn_c < 100) begin
              @(negedge clk); turn_c++;
              if (turn_c == H) tgt_en = 1'b0;
              if (line_oe === 1'b1) break;
            end
            for (int k = 0; k < NTX; k++) t_recv(8, lowcnt, tv[k]);
          end
        end
      end
    join
    if (mode == 0 || mode == 1) begin
      // lowcnt was overwritten by byte chunks in mode 0; index checks use iv
    end
    chk(iv[7:4] == 4'(i), "R4 index field", int'(iv[7:4]), i);
    chk(iv[3:1] == 3'($countones(4'(i))), "R4 ones count", int'(iv[3:1]), $countones(4'(i)));
    chk(iv[0] == ^iv[7:1], "R4 index parity", int'(iv[0]), int'(^iv[7:1]));
    chk(d_oe == 1 && d_out == 1, "R10 line high at done", d_oe * 2 + d_out, 3);
    chk(d_next == 0, "R11 done one clock", d_next, 0);
    if (mode == 0) begin
      chk(res == 0, "R10 result end", res, 0);
      chk(rx_n == NRX, "R6 rx count", rx_n, NRX);
      for (int k = 0; k < NRX && k < rx_n; k++)
        chk(rx_got[k] == rxb(i, k), "R6 rx byte", int'(rx_got[k]), int'(rxb(i, k)));
      chk(turn_c == B + 3, "R8 turnaround delay", turn_c, B + 3);
      chk(cont == 0, "R8 no contention", cont, 0);
      for (int k = 0; k < NTX; k++) begin
        chk(tv[k][8:1] == txb(i, k), "R9 tx byte", int'(tv[k][8:1]), int'(txb(i, k)));
        chk(tv[k][0] == ^tv[k][8:1], "R9 tx parity", int'(tv[k][0]), int'(^tv[k][8:1]));
      end
      chk(tx_ptr == NTX, "R9 tx handshakes", tx_ptr, NTX);
    end else if (mode == 1) begin
      chk(res == 1, "R5 no response", res, 1);
      chk(rx_n == 0, "R5 no rx", rx_n, 0);
    end else begin
      chk(res == 2, "R7 data error", res, 2);
      chk(rx_n == badk, "R7 good bytes kept", rx_n, badk);
      for (int k = 0; k < badk && k < rx_n; k++)
        chk(rx_got[k] == rxb(i, k), "R7 rx byte", int'(rx_got[k]), int'(rxb(i, k)));
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic wake_check(input int i);
    int lowcnt;
    logic [8:0] iv;
    fork
      begin
        idx = 4'(i); start = 1'b1;
        @(negedge clk); start = 1'b0;
        do @(negedge clk); while (done !== 1'b1);
      end
      t_recv(7, lowcnt, iv);
    join
    chk(lowcnt == WK + B, "R3 wake plus sync low", lowcnt, WK + B);
    chk(result == 2'd1, "R5 silent target", int'(result), 1);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; idx = '0; tx_valid = 1'b1;
    tgt_en = 1'b0; tgt_val = 1'b1;
    for (int k = 0; k < NTX; k++) tx_mem[k] = '0;
    repeat (3) @(negedge clk);
    chk(line_oe && line_out, "R1 reset line high", int'(line_oe) * 2 + int'(line_out), 3);
    chk(!busy && !done, "R1 reset idle", int'(busy) * 2 + int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(line_oe && line_out && !busy, "R1 idle after reset", int'(line_oe) * 2 + int'(line_out), 3);

    for (int i = MAXI + 1; i < 16; i++) begin
      idx = 4'(i); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(done && result == 2'd3, "R2 type error", int'(result) + 4 * int'(done), 7);
      chk(line_oe && line_out && !busy, "R2 line untouched", int'(line_oe) * 2 + int'(line_out), 3);
      @(negedge clk);
      chk(!done && line_oe && line_out, "R11 type error strobe", int'(done), 0);
      chk(result == 2'd3, "R11 result held", int'(result), 3);
    end

    wake_check(3);
    wake_check(10);

    for (int i = 0; i <= MAXI; i++) run_txn(i, 0, (i % 2 == 0) ? 3 : 14, 0);
    run_txn(5, 1, 0, 0);
    run_txn(6, 2, 3, 0);
    run_txn(9, 2, 3, 1);
    run_txn(2, 0, 3, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule